// File: doc/BRIEF.md
# Step Synchronization Timer

This block paces the time step of a data-acquisition card. As the timing master, it loads a programmable period into a down-counter. Each time the counter runs out, it raises a one-cycle step pulse. The card's internal functions consume that pulse, and it can also be driven onto one chosen line of a small sync bus so that other cards can follow it.

As a follower, the block takes the step from line 0 of that bus. The input passes through a two-flop synchronizer and a rising-edge detector, and an integer factor divides it. A watchdog reports a lost sync as a sticky error.

A third mode, the free-running follower, keeps the local timer counting but ignores the bus input and never produces a step. A legacy path lets a 4-bit board index choose the mode instead of the mode field. A connector-select bit tells the I/O routing whether to use the internal or the external connector set. A small register port writes the settings and reads back the reload value, the live count and the status code.

The loss-of-sync monitor is a state machine with three states:

- `MON_IDLE`: the block is not a follower.
- `MON_ARMED`: the monitor counts cycles since the last input edge.
- `MON_LOST`: the timeout ran out.

Its transitions are:

- arm: `MON_IDLE` to `MON_ARMED` when follower mode starts.
- expire: `MON_ARMED` to `MON_LOST` after the limit with no edge.
- recover: `MON_LOST` to `MON_ARMED` on an edge.
- disarm: any state to `MON_IDLE` when follower mode ends.

Top module: `step_sync_timer`

## Requirements
- R1: In master mode (mode field bits [1:0] of register 0 equal to 0), `step_pulse` is high for one cycle every PERIOD cycles, where PERIOD is register 1 and a value of 0 acts as 1. Writing register 1 restarts the count, so that the first pulse rises PERIOD cycles after the write edge.
- R2: When bit 2 of register 0 is set and the mode is master, exactly one bit of `sync_bus_oe` is set. That bit is the line chosen by register 4, which resets to line 0. `sync_bus_out` copies `step_pulse` on that line only. In every other case `sync_bus_oe` is zero.
- R3: In slave mode (mode 1), each rising edge of `sync_line0_in` advances a divider. A step is issued on every Nth edge, where N is register 2 and a value of 0 acts as 1. The step appears at most 3 cycles after the input rises.
- R4: The divider restarts from zero whenever the effective mode changes or register 2 is written.
- R5: In free-running follower mode (mode 2 or 3), the timer keeps counting and its count is readable at address 6. `step_pulse` stays low and the sync input has no effect.
- R6: In slave mode, if no input edge arrives for the number of cycles in register 3 (0 disables the check), a sticky error is set. Any write to address 5 clears it. While the mode is slave and the error is set, `status_code` reads 0xFF (-1), and address 7 reads -1 sign-extended.
- R7: In master mode and in free-running follower mode, `status_code` is 0 whatever the error flag holds.
- R8: While `legacy_sel` is high, the mode comes from `board_idx`: a value of 15 selects master, and any other value selects slave. The mode field is then ignored.
- R9: `ext_conn_sel` follows bit 3 of register 0 (1 selects the external connector set).
- R10: `cfg_rdata` returns the following, selected by `cfg_addr`: 0 control, 1 period, 2 divide factor, 3 timeout, 4 line select, 6 live timer count, 7 status.
- R11: After reset, the block is in master mode with the bus not driven, the internal connectors selected, line 0 selected, the period and timeout at their parameter defaults, and `status_code` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address (write and read) |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| legacy_sel | input | 1 | Take the mode from the board index |
| board_idx | input | 4 | Board index for legacy mode selection |
| sync_line0_in | input | 1 | Sync bus line 0, the follower input |
| sync_bus_out | output | LINES | Step pulse driven onto the sync bus |
| sync_bus_oe | output | LINES | Per-line drive enable for the sync bus |
| step_pulse | output | 1 | One-cycle step for internal consumers |
| ext_conn_sel | output | 1 | 1 routes I/O to the external connectors |
| status_code | output | 8 | Signed status: -1 on sync loss in slave mode, else 0 |

## Verification
The bench builds the block with its default parameters: four bus lines, a 16-bit period counter, an 8-bit divider and a 100-cycle reset period. With four lines, a non-zero line selection can be observed on distinct output bits. The 16-bit counter admits the degenerate periods 0 and 1, which the bench writes at run time next to ordinary ones. The bench also shortens the timeout to 20 cycles, so that loss of sync, its stickiness and its clearing all fall within a short run.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [1:0] {
        MODE_MASTER = 2'd0,
        MODE_SLAVE  = 2'd1,
        MODE_FREE   = 2'd2
    } ss_mode_e;

    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_ARMED = 2'd1,
        MON_LOST  = 2'd2
    } mon_state_e;

    localparam int ADR_CTRL    = 0;
    localparam int ADR_PERIOD  = 1;
    localparam int ADR_DIVIDE  = 2;
    localparam int ADR_TIMEOUT = 3;
    localparam int ADR_LINE    = 4;
    localparam int ADR_CLRERR  = 5;
    localparam int ADR_COUNT   = 6;
    localparam int ADR_STATUS  = 7;

    function automatic ss_mode_e decode_mode(input logic [1:0] field);
        unique case (field)
            2'd0:    return MODE_MASTER;
            2'd1:    return MODE_SLAVE;
            default: return MODE_FREE;
        endcase
    endfunction

endpackage

// File: rtl/ss_period_timer.sv
module ss_period_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 99
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_m1;

    // A period of zero behaves as a period of one
    assign top_m1 = (period_i == '0) ? '0 : period_i - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load_i) begin
            cnt_q <= top_m1;
        end else if (run_i) begin
            if (cnt_q == '0) cnt_q <= top_m1;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = run_i && !load_i && (cnt_q == '0);
    assign count_o  = cnt_q;

    a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |-> (cnt_q <= top_m1));

endmodule

// File: rtl/ss_slave_front.sv
module ss_slave_front #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sync_i,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             edge_o,
    output logic             step_o
);
    logic [2:0]       sh_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim = (div_i == '0) ? '0 : div_i - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], sync_i};
    end

    assign edge_o = en_i && sh_q[1] && !sh_q[2];

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (edge_o) begin
            if (cnt_q >= lim) cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
        end
    end

    assign step_o = edge_o && (cnt_q >= lim);

    a_r4_divider_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    a_r3_divider_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && !$changed(div_i) |=> (cnt_q <= lim));

endmodule

// File: rtl/ss_sync_monitor.sv
module ss_sync_monitor
    import ss_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            edge_i,
    input  logic [TO_W-1:0] limit_i,
    input  logic            clr_err_i,
    output logic            err_o
);
    mon_state_e      state_q, state_d;
    logic [TO_W-1:0] tcnt_q;
    logic            expired;

    assign expired = !edge_i && (limit_i != '0) && (tcnt_q >= limit_i - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_IDLE:  if (en_i) state_d = MON_ARMED;
            MON_ARMED: begin
                if (!en_i)        state_d = MON_IDLE;
                else if (expired) state_d = MON_LOST;
            end
            MON_LOST: begin
                if (!en_i)       state_d = MON_IDLE;
                else if (edge_i) state_d = MON_ARMED;
            end
            default: state_d = MON_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MON_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            err_o  <= 1'b0;
        end else begin
            if (state_q != MON_ARMED || edge_i) tcnt_q <= '0;
            else                                tcnt_q <= tcnt_q + 1'b1;
            if (clr_err_i)
                err_o <= 1'b0;
            else if (state_q == MON_ARMED && state_d == MON_LOST)
                err_o <= 1'b1;
        end
    end

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !clr_err_i |=> err_o);

    a_r6_loss_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == MON_LOST) && !$past(clr_err_i) |-> err_o);

    a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == MON_IDLE));

endmodule

// File: rtl/step_sync_timer.sv
module step_sync_timer
    import ss_pkg::*;
#(
    parameter int LINES       = 4,
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 8,
    parameter int TO_W        = 16,
    parameter int AW          = 3,
    parameter int DW          = 32,
    parameter int DEF_PERIOD  = 100,
    parameter int DEF_TIMEOUT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             legacy_sel,
    input  logic [3:0]       board_idx,
    input  logic             sync_line0_in,
    output logic [LINES-1:0] sync_bus_out,
    output logic [LINES-1:0] sync_bus_oe,
    output logic             step_pulse,
    output logic             ext_conn_sel,
    output logic [7:0]       status_code
);
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;

    logic [3:0]        ctrl_q;
    logic [CNT_W-1:0]  period_q;
    logic [DIV_W-1:0]  div_q;
    logic [TO_W-1:0]   to_q;
    logic [LINE_W-1:0] line_q;
    ss_mode_e          mode_eff, mode_prev_q;

    logic wr_ctrl, wr_period, wr_div, wr_to, wr_line, wr_clr;
    assign wr_ctrl   = cfg_we && (cfg_addr == AW'(ADR_CTRL));
    assign wr_period = cfg_we && (cfg_addr == AW'(ADR_PERIOD));
    assign wr_div    = cfg_we && (cfg_addr == AW'(ADR_DIVIDE));
    assign wr_to     = cfg_we && (cfg_addr == AW'(ADR_TIMEOUT));
    assign wr_line   = cfg_we && (cfg_addr == AW'(ADR_LINE));
    assign wr_clr    = cfg_we && (cfg_addr == AW'(ADR_CLRERR));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= CNT_W'(DEF_PERIOD);
            div_q    <= DIV_W'(1);
            to_q     <= TO_W'(DEF_TIMEOUT);
            line_q   <= '0;
        end else begin
            if (wr_ctrl)   ctrl_q   <= cfg_wdata[3:0];
            if (wr_period) period_q <= cfg_wdata[CNT_W-1:0];
            if (wr_div)    div_q    <= cfg_wdata[DIV_W-1:0];
            if (wr_to)     to_q     <= cfg_wdata[TO_W-1:0];
            if (wr_line)   line_q   <= cfg_wdata[LINE_W-1:0];
        end
    end

    always_comb begin
        if (legacy_sel) mode_eff = (board_idx == 4'hF) ? MODE_MASTER : MODE_SLAVE;
        else            mode_eff = decode_mode(ctrl_q[1:0]);
    end

    logic             is_master, is_slave, mode_chg;
    logic [CNT_W-1:0] tmr_period, tmr_count;
    logic             tmr_expire, slv_edge, slv_step, sync_err;

    assign is_master  = (mode_eff == MODE_MASTER);
    assign is_slave   = (mode_eff == MODE_SLAVE);
    assign mode_chg   = (mode_eff != mode_prev_q);
    assign tmr_period = wr_period ? cfg_wdata[CNT_W-1:0] : period_q;

    ss_period_timer #(.CNT_W(CNT_W), .RST_VAL(DEF_PERIOD - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (!is_slave),
        .load_i   (wr_period),
        .period_i (tmr_period),
        .count_o  (tmr_count),
        .expire_o (tmr_expire)
    );

    ss_slave_front #(.DIV_W(DIV_W)) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (is_slave),
        .sync_i (sync_line0_in),
        .clr_i  (mode_chg || wr_div),
        .div_i  (div_q),
        .edge_o (slv_edge),
        .step_o (slv_step)
    );

    ss_sync_monitor #(.TO_W(TO_W)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (is_slave),
        .edge_i    (slv_edge),
        .limit_i   (to_q),
        .clr_err_i (wr_clr),
        .err_o     (sync_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_pulse  <= 1'b0;
            mode_prev_q <= MODE_MASTER;
        end else begin
            step_pulse  <= (is_master && tmr_expire) || (is_slave && slv_step);
            mode_prev_q <= mode_eff;
        end
    end

    logic drive_act;
    assign drive_act    = is_master && ctrl_q[2];
    assign ext_conn_sel = ctrl_q[3];
    assign status_code  = (is_slave && sync_err) ? 8'hFF : 8'h00;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign sync_bus_oe[i]  = drive_act && (line_q == LINE_W'(i));
        assign sync_bus_out[i] = sync_bus_oe[i] && step_pulse;
    end

    always_comb begin
        unique case (int'(cfg_addr))
            ADR_CTRL:    cfg_rdata = DW'(ctrl_q);
            ADR_PERIOD:  cfg_rdata = DW'(period_q);
            ADR_DIVIDE:  cfg_rdata = DW'(div_q);
            ADR_TIMEOUT: cfg_rdata = DW'(to_q);
            ADR_LINE:    cfg_rdata = DW'(line_q);
            ADR_COUNT:   cfg_rdata = DW'(tmr_count);
            ADR_STATUS:  cfg_rdata = {{(DW-8){status_code[7]}}, status_code};
            default:     cfg_rdata = '0;
        endcase
    end

    a_r2_oe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sync_bus_oe));

    a_r2_out_inside_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_bus_out & ~sync_bus_oe) == '0);

    a_r5_free_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == MODE_FREE) |=> !step_pulse);

    a_r7_master_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err && !is_slave |-> (status_code == 8'h00));

endmodule

// File: tb/step_sync_timer_tb.sv
module step_sync_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        legacy_sel = 1'b0;
    logic [3:0]  board_idx = 4'd0;
    logic        sync_line0_in = 1'b0;
    logic [3:0]  sync_bus_out, sync_bus_oe;
    logic        step_pulse, ext_conn_sel;
    logic [7:0]  status_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_sync_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .legacy_sel(legacy_sel),
        .board_idx(board_idx), .sync_line0_in(sync_line0_in),
        .sync_bus_out(sync_bus_out), .sync_bus_oe(sync_bus_oe),
        .step_pulse(step_pulse), .ext_conn_sel(ext_conn_sel),
        .status_code(status_code)
    );

    int checks = 0;
    int failures = 0;
    int step_cnt = 0;
    logic cnt_en = 1'b0;
    logic done = 1'b0;

    always @(negedge clk) if (cnt_en && step_pulse) step_cnt++;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] period;
        logic [7:0]  div;
        logic [7:0]  npulse;
        logic [7:0]  expect_steps;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'd0, 16'd8,  8'd1, 8'd0,  8'd12},  // R1 master P=8
        '{2'd0, 16'd12, 8'd1, 8'd0,  8'd8},   // R1 master P=12
        '{2'd0, 16'd1,  8'd1, 8'd0,  8'd96},  // R1 master P=1
        '{2'd0, 16'd0,  8'd1, 8'd0,  8'd96},  // R1 period 0 acts as 1
        '{2'd1, 16'd8,  8'd1, 8'd10, 8'd10},  // R3 slave divide 1
        '{2'd1, 16'd8,  8'd3, 8'd10, 8'd3},   // R3 slave divide 3
        '{2'd1, 16'd8,  8'd0, 8'd6,  8'd6},   // R3 divide 0 acts as 1
        '{2'd2, 16'd8,  8'd1, 8'd10, 8'd0},   // R5 free mode ignores input
        '{2'd1, 16'd8,  8'd4, 8'd8,  8'd2}    // R3 slave divide 4
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cfg_we = 1'b1;
        cfg_addr = 3'(a);
        cfg_wdata = d;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        cfg_addr = 3'(a);
        #1;
        d = cfg_rdata;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            sync_line0_in = 1'b1;
            cyc();
            sync_line0_in = 1'b0;
            repeat (7) cyc();
        end
    endtask

    task automatic wait_step(output int n);
        n = 0;
        do begin
            cyc();
            n++;
        end while (!step_pulse && n < 300);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r2;
        int n;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R11 reset state
        check("R11 step", 32'(step_pulse), 0);
        check("R11 status", 32'(status_code), 0);
        check("R11 oe", 32'(sync_bus_oe), 0);
        check("R11 ext", 32'(ext_conn_sel), 0);
        rd(1, r); check("R11 period", r, 100);
        rd(4, r); check("R11 line", r, 0);
        rd(0, r); check("R11 ctrl", r, 0);

        // table-driven pass
        for (int v = 0; v < 9; v++) begin
            wr(0, 32'(VECS[v].mode));
            wr(2, 32'(VECS[v].div));
            wr(1, 32'(VECS[v].period));
            cyc();
            step_cnt = 0;
            cnt_en = 1'b1;
            if (VECS[v].npulse == 0) repeat (W) cyc();
            else begin
                pulses(int'(VECS[v].npulse));
                repeat (12) cyc();
            end
            cnt_en = 1'b0;
            check($sformatf("R1/R3/R5 vector %0d steps", v), 32'(step_cnt), 32'(VECS[v].expect_steps));
        end

        // R1 interval after restart
        wr(0, 0);
        wr(1, 5);
        wait_step(n);
        wait_step(n);
        check("R1 interval", 32'(n), 5);

        // R2 default line, then line 2
        wr(0, 32'h4);
        check("R2 default line oe", 32'(sync_bus_oe), 32'h1);
        wr(4, 2);
        check("R2 line2 oe", 32'(sync_bus_oe), 32'h4);
        wait_step(n);
        check("R2 out on step", 32'(sync_bus_out), 32'h4);
        cyc();
        check("R2 out between steps", 32'(sync_bus_out), 0);
        wr(0, 32'h5);
        check("R2 no drive in slave", 32'(sync_bus_oe), 0);

        // R4 divider restart on mode change
        wr(0, 1);
        wr(2, 3);
        pulses(2);
        wr(0, 0);
        repeat (3) cyc();
        wr(0, 1);
        cyc();
        step_cnt = 0;
        cnt_en = 1'b1;
        pulses(1);
        repeat (4) cyc();
        check("R4 mode change clears divider", 32'(step_cnt), 0);
        pulses(2);
        repeat (4) cyc();
        cnt_en = 1'b0;
        check("R4 third edge after restart", 32'(step_cnt), 1);

        // R5 free-running count
        wr(0, 2);
        wr(1, 50);
        rd(6, r);
        repeat (3) cyc();
        rd(6, r2);
        check("R5 count advances", 32'(r != r2), 1);

        // R6 sync loss
        wr(3, 20);
        wr(0, 1);
        repeat (40) cyc();
        check("R6 loss status", 32'(status_code), 32'hFF);
        rd(7, r); check("R6 status readback", r, 32'hFFFF_FFFF);
        pulses(1);
        check("R6 sticky after edge", 32'(status_code), 32'hFF);
        wr(5, 0);
        check("R6 cleared", 32'(status_code), 0);
        repeat (40) cyc();
        check("R6 relost", 32'(status_code), 32'hFF);
        wr(0, 0);
        check("R7 master status", 32'(status_code), 0);
        wr(0, 2);
        check("R7 free status", 32'(status_code), 0);

        // R8 legacy selection
        wr(5, 0);
        wr(3, 0);
        wr(2, 1);
        wr(1, 10);
        legacy_sel = 1'b1;
        board_idx = 4'd15;
        cyc();
        step_cnt = 0;
        cnt_en = 1'b1;
        repeat (40) cyc();
        cnt_en = 1'b0;
        check("R8 index 15 is master", 32'(step_cnt), 4);
        board_idx = 4'd14;
        repeat (3) cyc();
        step_cnt = 0;
        cnt_en = 1'b1;
        repeat (30) cyc();
        check("R8 index 14 no local steps", 32'(step_cnt), 0);
        pulses(4);
        repeat (6) cyc();
        cnt_en = 1'b0;
        check("R8 index 14 follows input", 32'(step_cnt), 4);
        legacy_sel = 1'b0;

        // R9 connector select
        wr(0, 32'h8);
        check("R9 external", 32'(ext_conn_sel), 1);
        wr(0, 32'h0);
        check("R9 internal", 32'(ext_conn_sel), 0);

        // R10 readback
        wr(2, 7);
        rd(2, r); check("R10 divide readback", r, 7);
        wr(3, 333);
        rd(3, r); check("R10 timeout readback", r, 333);
        rd(1, r); check("R10 period readback", r, 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule